// File: doc/BRIEF.md
# Load/Store Buffer Cache Issue Arbiter

This block tracks the memory operations held in an age-ordered circular buffer and decides, every cycle, which of them go to the data cache and which one, if any, goes to the uncached port. Each occupied slot carries six status flags: pending, conflict, uncached, cached, done and failed. The flags are set when the slot is allocated and are updated from data-readiness pulses, conflict-clear results, cache offers and uncached acknowledgements. When the issue stage tries to allocate and every slot is occupied, the block raises a stall.

Each slot runs a small state machine with three states. In `SL_FREE` the slot is empty. An *allocate* transition moves it to `SL_LIVE`, where its flags evolve. A *complete* transition moves it to `SL_DONE`: either the cache accepts the slot while it is not pending, or the uncached port acknowledges it. A *retire* transition returns the oldest done slot to `SL_FREE`, at most one slot per cycle. A *flush* transition takes every slot to `SL_FREE` from any state. The scan looks only at registered state. A flag change made at a clock edge therefore affects the scan of the following cycle.

The cache tells the block how many requests it can take this cycle (`cache_slots`). The scan gives those slots to the oldest eligible live entries. If one more entry is eligible after the slots are used up, it is presented, rejected and marked failed, and the scan stops at that entry.

Top module: `lsb_issue_arb`

## Requirements
- R1: After reset or a cycle with `flush` high, every slot is free. `alloc_idx` is 0, `cache_req` is all zero and `unc_req` is low.
- R2: `stall_full` is high exactly when `alloc_valid` is high and all DEPTH slots are occupied (live or done). A stalled request allocates nothing, and `alloc_idx` does not advance.
- R3: An accepted allocation fills slot `alloc_idx`, which then advances by one modulo DEPTH. Slots are freed strictly from the oldest end, one per cycle, once the oldest slot is done.
- R4: A store allocated with `alloc_data_busy` high is pending. It may still be sent to the cache, but acceptance then sets cached without completing it. A `data_ready` pulse on its slot clears both pending and cached at the edge, so the store is offered again in the next cycle. An acceptance while it is not pending completes it.
- R5: A load allocated with `alloc_fwd_hit` high is pending if the store at `alloc_fwd_idx` is still pending after that edge. At any edge where some store leaves pending, each pending load whose forwarding store is not pending after that edge clears its pending and cached flags.
- R6: An entry allocated with `alloc_conflict` high (and not uncached) is not sent to the cache until a `conflict_clear` pulse on its slot clears the flag.
- R7: The scan visits live entries from oldest to youngest and skips done and free slots. An entry with none of the uncached, cached or conflict flags set is a cache candidate. At most CACHE_W candidates are accepted per cycle, and the scan ends at the CACHE_W-th acceptance. `cache_req` bit i marks slot i presented this cycle.
- R8: If a candidate is reached after `cache_slots` acceptances, it is still presented on `cache_req`, but it is rejected and marked failed. Nothing younger is considered in that cycle. The rejected entry is offered again in later cycles.
- R9: With `precise` low, an uncached entry that is not pending issues on `unc_req`/`unc_idx` only when its `nonspec` bit is set. At most one issues per cycle, and issuing ends the scan. The entry completes when `unc_ack` is high in the cycle it is issued.
- R10: With `precise` high, an uncached entry issues only when `grad_valid` is high and `grad_idx` equals its slot. `nonspec` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Synchronous clear of all slots |
| precise | input | 1 | Uncached issue waits for the graduation head |
| alloc_valid | input | 1 | Allocation request from issue |
| alloc_store | input | 1 | New operation is a store |
| alloc_uncached | input | 1 | New operation takes the uncached path |
| alloc_data_busy | input | 1 | Store data register still being produced |
| alloc_fwd_hit | input | 1 | New load hits a buffered store |
| alloc_fwd_idx | input | IW | Slot of that store |
| alloc_conflict | input | 1 | Conflict result at allocation |
| alloc_idx | output | IW | Slot the next allocation takes |
| stall_full | output | 1 | Issue stall, buffer full |
| data_ready | input | DEPTH | Per slot: store data register became ready |
| conflict_clear | input | DEPTH | Per slot: conflict no longer present |
| nonspec | input | DEPTH | Per slot: instruction is non-speculative |
| grad_valid | input | 1 | Graduation head index is valid |
| grad_idx | input | IW | Slot at the graduation head |
| cache_slots | input | CW | Requests the cache can accept this cycle |
| cache_req | output | DEPTH | Per slot: presented to the cache this cycle |
| unc_ack | input | 1 | Uncached port takes the issued request |
| unc_req | output | 1 | Uncached request strobe |
| unc_idx | output | IW | Slot of the uncached request |

## Verification
The bench targets the edge where a store's data arrives. If the design does not clear the cached flag there, the store is never offered again and stays stuck, and a missing load release leaves the forwarding load stuck the same way. It drives the cache offer below the number of eligible entries, where a design that forgets to halt lets a younger entry or an uncached operation slip past the rejected one. It fills the buffer to check that the stall engages without moving the tail, and it checks that done entries leave only from the oldest end. It also checks both uncached issue modes, where a swapped qualifier would issue speculative uncached operations or stall the head forever.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    typedef enum logic [1:0] {
        SL_FREE = 2'd0,
        SL_LIVE = 2'd1,
        SL_DONE = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic is_store;
        logic pend;
        logic conf;
        logic unc;
        logic cach;
        logic fail;
    } slot_bits_t;

endpackage

// File: rtl/lsb_slot.sv
module lsb_slot
    import lsb_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          alloc_we,
    input  slot_bits_t    alloc_bits,
    input  logic [IW-1:0] alloc_fwd,
    input  logic          retire_we,
    input  logic          store_rel,
    input  logic          any_rel,
    input  logic          fwd_pend_nxt,
    input  logic          conf_clr,
    input  logic          cache_acc,
    input  logic          cache_rej,
    input  logic          unc_done,
    output slot_state_e   state_o,
    output slot_bits_t    bits_o,
    output logic [IW-1:0] fwd_o
);

    slot_state_e   st_q, st_n;
    slot_bits_t    b_q, b_n;
    logic [IW-1:0] fwd_q, fwd_n;
    logic          ld_rel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SL_FREE;
            b_q   <= '0;
            fwd_q <= '0;
        end else begin
            st_q  <= st_n;
            b_q   <= b_n;
            fwd_q <= fwd_n;
        end
    end

    always_comb begin
        st_n   = st_q;
        b_n    = b_q;
        fwd_n  = fwd_q;
        ld_rel = (st_q == SL_LIVE) && !b_q.is_store && b_q.pend
                 && any_rel && !fwd_pend_nxt;
        unique case (st_q)
            SL_FREE: begin
                if (alloc_we) begin
                    st_n  = SL_LIVE;
                    b_n   = alloc_bits;
                    fwd_n = alloc_fwd;
                end
            end
            SL_LIVE: begin
                if (conf_clr)  b_n.conf = 1'b0;
                if (cache_rej) b_n.fail = 1'b1;
                if (cache_acc) begin
                    b_n.fail = 1'b0;
                    b_n.cach = 1'b1;
                    if (!b_q.pend) st_n = SL_DONE;
                end
                if (unc_done) st_n = SL_DONE;
                if (store_rel || ld_rel) begin
                    b_n.pend = 1'b0;
                    b_n.cach = 1'b0;
                end
            end
            SL_DONE: begin
                if (retire_we) st_n = SL_FREE;
            end
            default: st_n = SL_FREE;
        endcase
        if (flush) st_n = SL_FREE;
    end

    assign state_o = st_q;
    assign bits_o  = b_q;
    assign fwd_o   = fwd_q;

    // R4: a released store loses pending and cached at that edge
    a_r4_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (store_rel && st_q == SL_LIVE && !flush) |=> (!b_q.pend && !b_q.cach));

    // R3: allocation only lands in an empty slot
    a_r3_alloc_into_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_we |-> (st_q == SL_FREE));

    // R3: a completed slot never becomes live again without being freed
    a_r3_done_not_live: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SL_DONE) |=> (st_q != SL_LIVE));

endmodule

// File: rtl/lsb_ring.sv
module lsb_ring #(
    parameter int DEPTH = 8,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          alloc_req,
    input  logic          head_done,
    output logic [IW-1:0] head,
    output logic [IW-1:0] tail,
    output logic          full,
    output logic          alloc_we,
    output logic          retire_we
);

    localparam logic [IW:0] CAP = (IW+1)'(DEPTH);

    logic [IW:0] cnt;

    assign full      = (cnt == CAP);
    assign alloc_we  = alloc_req && !full;
    assign retire_we = head_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else if (flush) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else begin
            if (alloc_we)  tail <= tail + 1'b1;
            if (retire_we) head <= head + 1'b1;
            cnt <= cnt + {{IW{1'b0}}, alloc_we} - {{IW{1'b0}}, retire_we};
        end
    end

    // R2: occupancy never exceeds the buffer size
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP);

    // R2: a full buffer with nothing leaving stays full
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !retire_we && !flush) |=> full);

endmodule

// File: rtl/lsb_scan.sv
module lsb_scan #(
    parameter int DEPTH   = 8,
    parameter int IW      = 3,
    parameter int CACHE_W = 2,
    parameter int CW      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IW-1:0]    head,
    input  logic [DEPTH-1:0] live_v,
    input  logic [DEPTH-1:0] unc_v,
    input  logic [DEPTH-1:0] cach_v,
    input  logic [DEPTH-1:0] conf_v,
    input  logic [DEPTH-1:0] pend_v,
    input  logic [DEPTH-1:0] fail_v,
    input  logic [CW-1:0]    slots,
    input  logic [DEPTH-1:0] nonspec,
    input  logic             precise,
    input  logic             grad_valid,
    input  logic [IW-1:0]    grad_idx,
    output logic [DEPTH-1:0] req,
    output logic [DEPTH-1:0] acc,
    output logic [DEPTH-1:0] rej,
    output logic             unc_req,
    output logic [IW-1:0]    unc_idx
);

    logic [IW-1:0] idx;
    logic          stop;
    logic          may_unc;
    int            n;

    always_comb begin
        req     = '0;
        acc     = '0;
        rej     = '0;
        unc_req = 1'b0;
        unc_idx = '0;
        stop    = 1'b0;
        idx     = '0;
        may_unc = 1'b0;
        n       = 0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + IW'(k);
            if (!stop && live_v[idx]) begin
                if (!unc_v[idx] && !cach_v[idx] && !conf_v[idx]) begin
                    req[idx] = 1'b1;
                    if (n < int'(slots)) begin
                        acc[idx] = 1'b1;
                        n = n + 1;
                        if (n == CACHE_W) stop = 1'b1;
                    end else begin
                        rej[idx] = 1'b1;
                        stop = 1'b1;
                    end
                end else if (unc_v[idx] && !pend_v[idx]) begin
                    may_unc = precise ? (grad_valid && grad_idx == idx) : nonspec[idx];
                    if (may_unc) begin
                        unc_req = 1'b1;
                        unc_idx = idx;
                        stop    = 1'b1;
                    end
                end
                if (fail_v[idx] && !acc[idx]) stop = 1'b1;
            end
        end
    end

    // R7: cache bandwidth bound
    a_r7_bandwidth: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(acc) <= CACHE_W);

    // R7: uncached entries never reach the cache
    a_r7_no_uncached_to_cache: assert property (@(posedge clk) disable iff (!rst_n)
        (req & unc_v) == '0);

    // R8: at most one rejection, and it ends the scan
    a_r8_single_reject: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rej) && !(rej != '0 && unc_req));

    // R9: an uncached issue targets a ready uncached live entry
    a_r9_unc_ready: assert property (@(posedge clk) disable iff (!rst_n)
        unc_req |-> (live_v[unc_idx] && unc_v[unc_idx] && !pend_v[unc_idx]));

endmodule

// File: rtl/lsb_issue_arb.sv
module lsb_issue_arb
    import lsb_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int CACHE_W = 2,
    localparam int IW     = $clog2(DEPTH),
    localparam int CW     = $clog2(CACHE_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             precise,
    input  logic             alloc_valid,
    input  logic             alloc_store,
    input  logic             alloc_uncached,
    input  logic             alloc_data_busy,
    input  logic             alloc_fwd_hit,
    input  logic [IW-1:0]    alloc_fwd_idx,
    input  logic             alloc_conflict,
    output logic [IW-1:0]    alloc_idx,
    output logic             stall_full,
    input  logic [DEPTH-1:0] data_ready,
    input  logic [DEPTH-1:0] conflict_clear,
    input  logic [DEPTH-1:0] nonspec,
    input  logic             grad_valid,
    input  logic [IW-1:0]    grad_idx,
    input  logic [CW-1:0]    cache_slots,
    output logic [DEPTH-1:0] cache_req,
    input  logic             unc_ack,
    output logic             unc_req,
    output logic [IW-1:0]    unc_idx
);

    slot_state_e      st   [DEPTH];
    slot_bits_t       bits [DEPTH];
    logic [IW-1:0]    fwd  [DEPTH];
    logic [DEPTH-1:0] live_v, unc_v, cach_v, conf_v, pend_v, fail_v;
    logic [DEPTH-1:0] rel_v, spn_v, acc, rej;
    logic [IW-1:0]    head, tail;
    logic             full, alloc_we, retire_we, any_rel;
    slot_bits_t       new_bits;

    lsb_ring #(.DEPTH(DEPTH), .IW(IW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .alloc_req (alloc_valid),
        .head_done (st[head] == SL_DONE),
        .head      (head),
        .tail      (tail),
        .full      (full),
        .alloc_we  (alloc_we),
        .retire_we (retire_we)
    );

    assign any_rel = |rel_v;

    always_comb begin
        new_bits          = '0;
        new_bits.is_store = alloc_store;
        new_bits.unc      = alloc_uncached;
        new_bits.conf     = !alloc_uncached && alloc_conflict;
        new_bits.pend     = alloc_store ? alloc_data_busy
                                        : (alloc_fwd_hit && spn_v[alloc_fwd_idx]);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign live_v[i] = (st[i] == SL_LIVE);
        assign unc_v[i]  = bits[i].unc;
        assign cach_v[i] = bits[i].cach;
        assign conf_v[i] = bits[i].conf;
        assign pend_v[i] = bits[i].pend;
        assign fail_v[i] = bits[i].fail;
        assign rel_v[i]  = live_v[i] && bits[i].is_store && bits[i].pend && data_ready[i];
        assign spn_v[i]  = live_v[i] && bits[i].is_store && bits[i].pend && !data_ready[i];

        lsb_slot #(.IW(IW)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .flush        (flush),
            .alloc_we     (alloc_we && tail == IW'(i)),
            .alloc_bits   (new_bits),
            .alloc_fwd    (alloc_fwd_idx),
            .retire_we    (retire_we && head == IW'(i)),
            .store_rel    (rel_v[i]),
            .any_rel      (any_rel),
            .fwd_pend_nxt (spn_v[fwd[i]]),
            .conf_clr     (conflict_clear[i]),
            .cache_acc    (acc[i]),
            .cache_rej    (rej[i]),
            .unc_done     (unc_req && unc_ack && unc_idx == IW'(i)),
            .state_o      (st[i]),
            .bits_o       (bits[i]),
            .fwd_o        (fwd[i])
        );
    end

    lsb_scan #(.DEPTH(DEPTH), .IW(IW), .CACHE_W(CACHE_W), .CW(CW)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (head),
        .live_v     (live_v),
        .unc_v      (unc_v),
        .cach_v     (cach_v),
        .conf_v     (conf_v),
        .pend_v     (pend_v),
        .fail_v     (fail_v),
        .slots      (cache_slots),
        .nonspec    (nonspec),
        .precise    (precise),
        .grad_valid (grad_valid),
        .grad_idx   (grad_idx),
        .req        (cache_req),
        .acc        (acc),
        .rej        (rej),
        .unc_req    (unc_req),
        .unc_idx    (unc_idx)
    );

    assign alloc_idx  = tail;
    assign stall_full = alloc_valid && full;

    // R1: a flush leaves nothing to issue in the next cycle
    a_r1_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cache_req == '0 && !unc_req));

    // R2: a stalled allocation does not move the tail
    a_r2_stall_holds_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_full && !flush) |=> $stable(alloc_idx));

endmodule

// File: tb/tb_lsb_issue_arb.sv
`timescale 1ns/1ps
module tb_lsb_issue_arb;

    localparam int D  = 8;
    localparam int W  = 2;
    localparam int IW = 3;
    localparam int CW = 2;

    logic clk = 1'b0;
    logic rst_n, flush, precise;
    logic alloc_valid, alloc_store, alloc_uncached, alloc_data_busy, alloc_fwd_hit, alloc_conflict;
    logic [IW-1:0] alloc_fwd_idx, grad_idx, alloc_idx, unc_idx;
    logic stall_full, grad_valid, unc_ack, unc_req;
    logic [D-1:0] data_ready, conflict_clear, nonspec, cache_req;
    logic [CW-1:0] cache_slots;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // model state: 0 free, 1 live, 2 done
    int m_st[D];
    bit m_store[D], m_pend[D], m_conf[D], m_unc[D], m_cach[D], m_fail[D];
    int m_fwd[D];
    int m_head, m_tail, m_cnt;

    always #2.5 clk = ~clk;

    lsb_issue_arb #(.DEPTH(D), .CACHE_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .precise(precise),
        .alloc_valid(alloc_valid), .alloc_store(alloc_store), .alloc_uncached(alloc_uncached),
        .alloc_data_busy(alloc_data_busy), .alloc_fwd_hit(alloc_fwd_hit), .alloc_fwd_idx(alloc_fwd_idx),
        .alloc_conflict(alloc_conflict), .alloc_idx(alloc_idx), .stall_full(stall_full),
        .data_ready(data_ready), .conflict_clear(conflict_clear), .nonspec(nonspec),
        .grad_valid(grad_valid), .grad_idx(grad_idx), .cache_slots(cache_slots),
        .cache_req(cache_req), .unc_ack(unc_ack), .unc_req(unc_req), .unc_idx(unc_idx)
    );

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        summary();
    end

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < D; i++) begin
            m_st[i] = 0; m_store[i] = 0; m_pend[i] = 0; m_conf[i] = 0;
            m_unc[i] = 0; m_cach[i] = 0; m_fail[i] = 0; m_fwd[i] = 0;
        end
        m_head = 0; m_tail = 0; m_cnt = 0;
    endtask

    task automatic idle();
        flush = 0; alloc_valid = 0; alloc_store = 0; alloc_uncached = 0;
        alloc_data_busy = 0; alloc_fwd_hit = 0; alloc_fwd_idx = '0; alloc_conflict = 0;
        data_ready = '0; conflict_clear = '0; nonspec = '0; grad_valid = 0;
        grad_idx = '0; cache_slots = '0; unc_ack = 0;
    endtask

    // One cycle: compare outputs against the model, advance the model.
    task automatic step(input string tag);
        logic [D-1:0] e_req, e_acc, e_rej;
        bit e_unc, stop, spn[D], rel[D], anyrel, ret, alw, ok;
        int e_uidx, n;
        #1;
        e_req = '0; e_acc = '0; e_rej = '0; e_unc = 0; e_uidx = 0; n = 0; stop = 0;
        for (int k = 0; k < D; k++) begin
            int idx = (m_head + k) % D;
            if (!stop && m_st[idx] == 1) begin
                if (!m_unc[idx] && !m_cach[idx] && !m_conf[idx]) begin
                    e_req[idx] = 1;
                    if (n < int'(cache_slots)) begin
                        e_acc[idx] = 1; n++;
                        if (n == W) stop = 1;
                    end else begin
                        e_rej[idx] = 1; stop = 1;
                    end
                end else if (m_unc[idx] && !m_pend[idx]) begin
                    ok = precise ? (grad_valid && int'(grad_idx) == idx) : nonspec[idx];
                    if (ok) begin e_unc = 1; e_uidx = idx; stop = 1; end
                end
                if (m_fail[idx] && !e_acc[idx]) stop = 1;
            end
        end
        check(tag, "stall_full", int'(stall_full), int'(alloc_valid && m_cnt == D));
        check(tag, "alloc_idx", int'(alloc_idx), m_tail);
        check(tag, "cache_req", int'(cache_req), int'(e_req));
        check(tag, "unc_req", int'(unc_req), int'(e_unc));
        check(tag, "unc_idx", int'(unc_idx), e_uidx);
        // next state
        anyrel = 0;
        for (int i = 0; i < D; i++) begin
            spn[i] = m_st[i] == 1 && m_store[i] && m_pend[i] && !data_ready[i];
            rel[i] = m_st[i] == 1 && m_store[i] && m_pend[i] && data_ready[i];
            anyrel |= rel[i];
        end
        ret = (m_st[m_head] == 2);
        alw = alloc_valid && m_cnt < D;
        for (int i = 0; i < D; i++) begin
            if (m_st[i] == 1) begin
                bit lrel = !m_store[i] && m_pend[i] && anyrel && !spn[m_fwd[i]];
                bit oldp = m_pend[i];
                if (conflict_clear[i]) m_conf[i] = 0;
                if (e_rej[i]) m_fail[i] = 1;
                if (e_acc[i]) begin m_fail[i] = 0; m_cach[i] = 1; if (!oldp) m_st[i] = 2; end
                if (e_unc && unc_ack && e_uidx == i) m_st[i] = 2;
                if (rel[i] || lrel) begin m_pend[i] = 0; m_cach[i] = 0; end
            end
        end
        if (ret) begin m_st[m_head] = 0; m_head = (m_head + 1) % D; m_cnt--; end
        if (alw) begin
            m_st[m_tail] = 1; m_store[m_tail] = alloc_store; m_unc[m_tail] = alloc_uncached;
            m_conf[m_tail] = !alloc_uncached && alloc_conflict;
            m_pend[m_tail] = alloc_store ? alloc_data_busy : (alloc_fwd_hit && spn[alloc_fwd_idx]);
            m_cach[m_tail] = 0; m_fail[m_tail] = 0; m_fwd[m_tail] = int'(alloc_fwd_idx);
            m_tail = (m_tail + 1) % D; m_cnt++;
        end
        if (flush) model_clear();
        @(negedge clk);
    endtask

    task automatic rand_inputs();
        int j;
        idle();
        alloc_valid     = ($urandom % 3) != 0;
        alloc_store     = $urandom % 2;
        alloc_uncached  = ($urandom % 5) == 0;
        alloc_data_busy = alloc_store && ($urandom % 2);
        alloc_conflict  = ($urandom % 4) == 0;
        j = $urandom % D;
        if (!alloc_store && m_st[j] == 1 && m_store[j]) begin
            alloc_fwd_hit = $urandom % 2; alloc_fwd_idx = IW'(j);
        end
        data_ready     = D'($urandom & $urandom);
        conflict_clear = D'($urandom & $urandom);
        nonspec        = D'($urandom);
        grad_valid     = $urandom % 2;
        grad_idx       = IW'($urandom);
        cache_slots    = CW'($urandom % (W + 1));
        unc_ack        = $urandom % 2;
        flush          = ($urandom % 97) == 0;
    endtask

    initial begin
        int s;
        void'($urandom(32'd20240611));
        model_clear();
        idle(); precise = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        step("R1");
        // R3/R6: fill with conflicting loads, none may go to the cache
        for (int i = 0; i < D; i++) begin
            idle(); alloc_valid = 1; alloc_conflict = 1; cache_slots = 2'd2; step("R6");
        end
        // R2: buffer full
        idle(); alloc_valid = 1; step("R2");
        idle(); alloc_valid = 1; cache_slots = 2'd2; step("R2");
        // R8: conflicts clear, cache offers nothing: oldest rejected, scan halts
        idle(); conflict_clear = '1; step("R8");
        idle(); step("R8");
        idle(); cache_slots = 2'd1; step("R8");
        // R7/R3: full bandwidth, ordered retirement
        for (int i = 0; i < 8; i++) begin idle(); cache_slots = 2'd2; step("R7"); end
        for (int i = 0; i < 6; i++) begin idle(); step("R3"); end
        // R1: flush
        idle(); alloc_valid = 1; flush = 1; step("R1");
        idle(); step("R1");
        // R4: store with busy data
        s = m_tail;
        idle(); alloc_valid = 1; alloc_store = 1; alloc_data_busy = 1; step("R4");
        idle(); cache_slots = 2'd1; step("R4");
        idle(); cache_slots = 2'd1; step("R4");
        idle(); data_ready[s] = 1; step("R4");
        idle(); cache_slots = 2'd1; step("R4");
        idle(); step("R4");
        idle(); step("R4");
        // R5: load forwarding from a pending store
        s = m_tail;
        idle(); alloc_valid = 1; alloc_store = 1; alloc_data_busy = 1; step("R5");
        idle(); alloc_valid = 1; alloc_fwd_hit = 1; alloc_fwd_idx = IW'(s); step("R5");
        idle(); cache_slots = 2'd2; step("R5");
        idle(); cache_slots = 2'd2; step("R5");
        idle(); data_ready[s] = 1; step("R5");
        idle(); cache_slots = 2'd2; step("R5");
        for (int i = 0; i < 3; i++) begin idle(); step("R5"); end
        // R9: uncached, speculation gating, one per cycle
        idle(); alloc_valid = 1; alloc_uncached = 1; step("R9");
        idle(); alloc_valid = 1; alloc_uncached = 1; step("R9");
        idle(); step("R9");
        idle(); nonspec = '1; step("R9");
        idle(); nonspec = '1; unc_ack = 1; step("R9");
        idle(); nonspec = '1; unc_ack = 1; step("R9");
        for (int i = 0; i < 3; i++) begin idle(); step("R9"); end
        // R10: precise mode follows the graduation head
        precise = 1;
        s = m_tail;
        idle(); alloc_valid = 1; alloc_uncached = 1; step("R10");
        idle(); nonspec = '1; step("R10");
        idle(); nonspec = '1; grad_valid = 1; grad_idx = IW'(s + 1); step("R10");
        idle(); grad_valid = 1; grad_idx = IW'(s); unc_ack = 1; step("R10");
        idle(); step("R10");
        // random phases
        precise = 0;
        for (int c = 0; c < 3000; c++) begin rand_inputs(); step("R7"); end
        precise = 1;
        for (int c = 0; c < 3000; c++) begin rand_inputs(); step("R10"); end
        summary();
    end

endmodule